// File: doc/BRIEF.md
# MDIO Management Bus Master

This block performs one register access at a time on a two-wire station management bus. It makes the management clock from the system clock and drives the bidirectional data line through a pad split into output, output-enable and input. For each access it drives the data line and then releases it to read. Both the short frame with a 5-bit register number and the extended indirect access are supported. The extended access sends an address frame that carries a 21-bit register address, then a second frame that reads or writes the data.

A command is presented with `cmdValid` while `busy` is low. It carries the direction, the extended-access flag, the 5-bit PHY number, the register address and the write data. The block raises `busy` for the whole access. It finishes with a one-cycle `done` pulse that carries the read result and the turnaround-error flag. Read frames check the turnaround bit that the PHY returns. If the bit is wrong and a per-PHY ignore mask does not excuse it, the block clocks the bus 32 more times to drain the PHY and returns all ones with an error.

Each management clock bit has a low phase of `LOW_CYC` system cycles and a high phase of `HIGH_CYC` system cycles. A bit the PHY drives, or a bit with the line released, uses a longer high phase of `RD_HIGH_CYC` cycles. The output changes at the start of the low phase. The input is taken at the last cycle of the high phase, which is the falling edge.

Top module: `mdio_master`

## Requirements
- R1: After reset and between accesses, `mdc` is 0, `mdioOe` is 0, and `busy` and `done` are 0.
- R2: Every frame starts with 32 driven 1 bits. Each driven bit holds `mdc` low for `LOW_CYC` cycles and then high for `HIGH_CYC` cycles. `mdioOut` changes only at the start of a low phase.
- R3: A short frame sends start code 01, then the opcode (10 = read, 01 = write), then the PHY number (5 bits), then `cmdAddr[4:0]` (5 bits). Every field goes out MSB first.
- R4: For a write frame or an address frame, the block drives the turnaround as 1 then 0 and sends 16 data bits MSB first. It then releases the line for one extra bit whose high phase lasts `RD_HIGH_CYC` cycles.
- R5: For a read frame, the line is released right after the register field. The turnaround and 16 data bits are sampled in the last cycle of each `RD_HIGH_CYC` high phase, MSB first, and one released extra bit follows. `done` then shows the captured word on `rdData` with `taErr` = 0.
- R6: If the sampled turnaround bit is 1 and bit `cmdPhy` of `ignoreTaMask` is 0, the block runs 32 released bits and ends without an extra bit. `done` then shows `rdData` = 16'hFFFF and `taErr` = 1.
- R7: If bit `cmdPhy` of `ignoreTaMask` is 1, a turnaround bit of 1 is accepted and the read completes as in R5.
- R8: When `cmdC45` = 1, the block first sends an address frame: start 00, opcode 00, register field `cmdAddr[20:16]`, data `cmdAddr[15:0]`. A second frame follows with start 00, opcode 01 (write) or 11 (read), and the same PHY and register field.
- R9: A command is accepted only when `cmdValid` is 1 and `busy` is 0. `busy` is 1 from the cycle after acceptance until `done`. `cmdValid` has no effect while `busy` is 1.
- R10: `done` is high for exactly one cycle. `taErr` changes only with `done`. A write ends with `taErr` = 0 and leaves `rdData` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdC45 | input | 1 | 1 = extended two-frame access |
| cmdPhy | input | 5 | PHY number |
| cmdAddr | input | 21 | Register address; bits 4:0 are used for short frames |
| cmdWdata | input | 16 | Write data |
| ignoreTaMask | input | 32 | Per-PHY turnaround-check bypass |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Read result |
| taErr | output | 1 | Turnaround error of the last read |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data line output value |
| mdioOe | output | 1 | Data line output enable |
| mdioIn | input | 1 | Data line input |

## Verification
The bench builds the block with `LOW_CYC` = 2, `HIGH_CYC` = 2 and `RD_HIGH_CYC` = 4. Because the released-bit high phase is twice the driven one, any bit that takes the wrong high length shifts every later cycle of the comparison. The short periods keep a full extended read with its address frame to a few hundred cycles, so the bench can run all frame types and the errored, excused and draining turnaround paths in one short run. A PHY bit-mask that excuses one address, and an error read followed by a write, exercise the mask lookup and the rule that a write keeps the previous `rdData`.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int PHY_W     = 5;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = DATA_W + PHY_W;
  localparam int MASK_W    = 1 << PHY_W;
  localparam int PRE_LEN   = 32;
  localparam int FLUSH_LEN = 32;
  localparam int HDR_LEN   = PRE_LEN + 4 + 2 * PHY_W;
  localparam int FULL_LEN  = HDR_LEN + 2 + DATA_W;
  localparam int BITS_W    = $clog2(FULL_LEN + 1);

  typedef enum logic [1:0] {
    FK_SHORT   = 2'd0,
    FK_EXTADDR = 2'd1,
    FK_EXTDATA = 2'd2
  } frameKindT;

  typedef struct packed {
    logic      accept;
    logic      load;
    frameKindT kind;
    logic      shiftTx;
    logic      shiftRx;
    logic      finishOk;
    logic      finishErr;
  } dpStrobeT;

endpackage

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          ctl,
  input  logic              cmdWrite,
  input  logic [PHY_W-1:0]  cmdPhy,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic [MASK_W-1:0] ignoreTaMask,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              taIgnore,
  output logic [DATA_W-1:0] rdData,
  output logic              taErr
);

  logic [FULL_LEN-1:0] txSh;
  logic [DATA_W-1:0]   rxSh;
  logic                wrQ;
  logic [PHY_W-1:0]    phyQ;
  logic [ADDR_W-1:0]   addrQ;
  logic [DATA_W-1:0]   wdQ;

  // command fields: straight from the port on the accept cycle, else held
  logic              selWr;
  logic [PHY_W-1:0]  selPhy;
  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] selWd;

  assign selWr   = ctl.accept ? cmdWrite : wrQ;
  assign selPhy  = ctl.accept ? cmdPhy   : phyQ;
  assign selAddr = ctl.accept ? cmdAddr  : addrQ;
  assign selWd   = ctl.accept ? cmdWdata : wdQ;

  logic [1:0]        stCode;
  logic [1:0]        opCode;
  logic [PHY_W-1:0]  regField;
  logic [DATA_W-1:0] payload;

  always_comb begin
    stCode   = 2'b00;
    opCode   = 2'b00;
    regField = selAddr[ADDR_W-1:DATA_W];
    payload  = selWd;
    case (ctl.kind)
      FK_SHORT: begin
        stCode   = 2'b01;
        opCode   = selWr ? 2'b01 : 2'b10;
        regField = selAddr[PHY_W-1:0];
      end
      FK_EXTADDR: begin
        payload  = selAddr[DATA_W-1:0];
      end
      default: begin
        opCode   = selWr ? 2'b01 : 2'b11;
      end
    endcase
  end

  logic [FULL_LEN-1:0] frameWord;
  assign frameWord = {{PRE_LEN{1'b1}}, stCode, opCode, selPhy, regField, 2'b10, payload};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrQ   <= 1'b0;
      phyQ  <= '0;
      addrQ <= '0;
      wdQ   <= '0;
    end else if (ctl.accept) begin
      wrQ   <= cmdWrite;
      phyQ  <= cmdPhy;
      addrQ <= cmdAddr;
      wdQ   <= cmdWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh <= '1;
    end else if (ctl.load) begin
      txSh <= frameWord;
    end else if (ctl.shiftTx) begin
      txSh <= {txSh[FULL_LEN-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSh <= '0;
    end else if (ctl.shiftRx) begin
      rxSh <= {rxSh[DATA_W-2:0], mdioIn};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
      taErr  <= 1'b0;
    end else if (ctl.finishErr) begin
      rdData <= '1;
      taErr  <= 1'b1;
    end else if (ctl.finishOk) begin
      if (!wrQ) rdData <= rxSh;
      taErr <= 1'b0;
    end
  end

  assign mdioOut  = txSh[FULL_LEN-1];
  assign taIgnore = ignoreTaMask[phyQ];

endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int LOW_CYC     = 20,
  parameter int HIGH_CYC    = 20,
  parameter int RD_HIGH_CYC = 35
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdValid,
  input  logic     cmdWrite,
  input  logic     cmdC45,
  input  logic     mdioIn,
  input  logic     taIgnore,
  output dpStrobeT ctl,
  output logic     busy,
  output logic     done,
  output logic     mdc,
  output logic     mdioOe
);

  localparam int MAXC  = (LOW_CYC > HIGH_CYC) ?
                         ((LOW_CYC > RD_HIGH_CYC) ? LOW_CYC : RD_HIGH_CYC) :
                         ((HIGH_CYC > RD_HIGH_CYC) ? HIGH_CYC : RD_HIGH_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_TX, S_TA, S_RX, S_FLUSH, S_TAIL
  } stateT;

  stateT             st, stN;
  logic              hi;
  logic [CNT_W-1:0]  cnt;
  logic [BITS_W-1:0] bitsLeft, bitsN;
  logic              isRd, isRdN;
  logic              addrPend, addrPendN;
  logic              doneN;

  logic             recv;
  logic [CNT_W-1:0] hiLast;
  logic             lowEnd;
  logic             bitEnd;
  logic             lastBit;

  assign recv    = (st == S_TA) || (st == S_RX) || (st == S_FLUSH) || (st == S_TAIL);
  assign hiLast  = recv ? CNT_W'(RD_HIGH_CYC - 1) : CNT_W'(HIGH_CYC - 1);
  assign lowEnd  = (st != S_IDLE) && !hi && (cnt == CNT_W'(LOW_CYC - 1));
  assign bitEnd  = (st != S_IDLE) && hi && (cnt == hiLast);
  assign lastBit = (bitsLeft == BITS_W'(1));

  always_comb begin
    ctl       = '0;
    stN       = st;
    bitsN     = bitsLeft;
    isRdN     = isRd;
    addrPendN = addrPend;
    doneN     = 1'b0;
    case (st)
      S_IDLE: begin
        if (cmdValid) begin
          ctl.accept = 1'b1;
          ctl.load   = 1'b1;
          ctl.kind   = cmdC45 ? FK_EXTADDR : FK_SHORT;
          stN        = S_TX;
          addrPendN  = cmdC45;
          isRdN      = !cmdWrite;
          bitsN      = (cmdC45 || cmdWrite) ? BITS_W'(FULL_LEN) : BITS_W'(HDR_LEN);
        end
      end
      S_TX: begin
        if (bitEnd) begin
          ctl.shiftTx = 1'b1;
          if (lastBit) stN = (isRd && !addrPend) ? S_TA : S_TAIL;
          else         bitsN = bitsLeft - BITS_W'(1);
        end
      end
      S_TA: begin
        if (bitEnd) begin
          if (!mdioIn || taIgnore) begin
            stN   = S_RX;
            bitsN = BITS_W'(DATA_W);
          end else begin
            stN   = S_FLUSH;
            bitsN = BITS_W'(FLUSH_LEN);
          end
        end
      end
      S_RX: begin
        if (bitEnd) begin
          ctl.shiftRx = 1'b1;
          if (lastBit) stN = S_TAIL;
          else         bitsN = bitsLeft - BITS_W'(1);
        end
      end
      S_FLUSH: begin
        if (bitEnd) begin
          if (lastBit) begin
            ctl.finishErr = 1'b1;
            doneN         = 1'b1;
            stN           = S_IDLE;
          end else begin
            bitsN = bitsLeft - BITS_W'(1);
          end
        end
      end
      S_TAIL: begin
        if (bitEnd) begin
          if (addrPend) begin
            addrPendN = 1'b0;
            ctl.load  = 1'b1;
            ctl.kind  = FK_EXTDATA;
            stN       = S_TX;
            bitsN     = isRd ? BITS_W'(HDR_LEN) : BITS_W'(FULL_LEN);
          end else begin
            ctl.finishOk = 1'b1;
            doneN        = 1'b1;
            stN          = S_IDLE;
          end
        end
      end
      default: stN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= S_IDLE;
      bitsLeft <= '0;
      isRd     <= 1'b0;
      addrPend <= 1'b0;
      done     <= 1'b0;
    end else begin
      st       <= stN;
      bitsLeft <= bitsN;
      isRd     <= isRdN;
      addrPend <= addrPendN;
      done     <= doneN;
    end
  end

  // bit clock: low phase, then high phase; every bit restarts in low
  always_ff @(posedge clk) begin
    if (!rstN || st == S_IDLE) begin
      hi  <= 1'b0;
      cnt <= '0;
    end else if (lowEnd) begin
      hi  <= 1'b1;
      cnt <= '0;
    end else if (bitEnd) begin
      hi  <= 1'b0;
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign busy   = (st != S_IDLE);
  assign mdc    = hi;
  assign mdioOe = (st == S_TX);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int LOW_CYC     = 20,
  parameter int HIGH_CYC    = 20,
  parameter int RD_HIGH_CYC = 35
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdWrite,
  input  logic        cmdC45,
  input  logic [4:0]  cmdPhy,
  input  logic [20:0] cmdAddr,
  input  logic [15:0] cmdWdata,
  input  logic [31:0] ignoreTaMask,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdData,
  output logic        taErr,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  dpStrobeT ctl;
  logic     taIgnore;

  mdio_ctrl #(
    .LOW_CYC    (LOW_CYC),
    .HIGH_CYC   (HIGH_CYC),
    .RD_HIGH_CYC(RD_HIGH_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdValid(cmdValid),
    .cmdWrite(cmdWrite),
    .cmdC45  (cmdC45),
    .mdioIn  (mdioIn),
    .taIgnore(taIgnore),
    .ctl     (ctl),
    .busy    (busy),
    .done    (done),
    .mdc     (mdc),
    .mdioOe  (mdioOe)
  );

  mdio_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .cmdWrite    (cmdWrite),
    .cmdPhy      (cmdPhy),
    .cmdAddr     (cmdAddr),
    .cmdWdata    (cmdWdata),
    .ignoreTaMask(ignoreTaMask),
    .mdioIn      (mdioIn),
    .mdioOut     (mdioOut),
    .taIgnore    (taIgnore),
    .rdData      (rdData),
    .taErr       (taErr)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int LOW_CYC = 20
) (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic [15:0] rdData,
  input logic        taErr,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe
);

  logic [15:0] lowRun;

  always_ff @(posedge clk) begin
    if (!rstN)              lowRun <= '0;
    else if (mdc)           lowRun <= '0;
    else if (lowRun != '1)  lowRun <= lowRun + 16'd1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe)); // R1

  AST_LOW_PHASE_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> (lowRun >= 16'(LOW_CYC))); // R2

  AST_OUT_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc) && mdioOe && $past(mdioOe)) |-> $stable(mdioOut)); // R2

  AST_OE_TURN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mdioOe) |-> !mdc); // R4

  AST_ERR_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (done && taErr) |-> (rdData == 16'hFFFF)); // R6

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(taErr) |-> done); // R10

endmodule

bind mdio_master mdio_master_chk #(.LOW_CYC(LOW_CYC)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busy   (busy),
  .done   (done),
  .rdData (rdData),
  .taErr  (taErr),
  .mdc    (mdc),
  .mdioOut(mdioOut),
  .mdioOe (mdioOe)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;

  localparam int LOW = 2;
  localparam int HIGH = 2;
  localparam int RDH = 4;
  localparam logic [31:0] MASK = 32'h0000_0200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdWrite = 1'b0;
  logic        cmdC45 = 1'b0;
  logic [4:0]  cmdPhy = '0;
  logic [20:0] cmdAddr = '0;
  logic [15:0] cmdWdata = '0;
  logic [31:0] ignoreTaMask = MASK;
  logic        busy, done, taErr, mdc, mdioOut, mdioOe;
  logic [15:0] rdData;
  logic        mdioIn = 1'b1;

  int nRun = 0;
  int nFail = 0;
  logic [15:0] lastRd = 16'h0000;

  bit    qMdc[$];
  bit    qOe[$];
  bit    qOut[$];
  bit    qIn[$];
  string qTag[$];

  always #5 clk = ~clk;

  mdio_master #(.LOW_CYC(LOW), .HIGH_CYC(HIGH), .RD_HIGH_CYC(RDH)) u_mdio_master (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite), .cmdC45(cmdC45),
    .cmdPhy(cmdPhy), .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .ignoreTaMask(ignoreTaMask),
    .busy(busy), .done(done), .rdData(rdData), .taErr(taErr), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pushBit(input bit v, input bit drv, input int hiLen, input bit inV, input string tag);
    for (int i = 0; i < LOW + hiLen; i++) begin
      qMdc.push_back(i >= LOW);
      qOe.push_back(drv);
      qOut.push_back(v);
      qIn.push_back(inV);
      qTag.push_back(tag);
    end
  endtask

  task automatic pushNum(input logic [15:0] val, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) pushBit(val[i], 1'b1, HIGH, 1'b1, tag);
  endtask

  task automatic pushHeader(input logic [1:0] stc, input logic [1:0] opc,
                            input logic [4:0] phy, input logic [4:0] rg, input string tag);
    for (int i = 0; i < 32; i++) pushBit(1'b1, 1'b1, HIGH, 1'b1, "R2");
    pushNum({14'd0, stc}, 2, tag);
    pushNum({14'd0, opc}, 2, tag);
    pushNum({11'd0, phy}, 5, tag);
    pushNum({11'd0, rg}, 5, tag);
  endtask

  task automatic pushDrivenTail(input logic [15:0] d, input string tag);
    pushBit(1'b1, 1'b1, HIGH, 1'b1, tag);
    pushBit(1'b0, 1'b1, HIGH, 1'b1, tag);
    pushNum(d, 16, tag);
    pushBit(1'b0, 1'b0, RDH, 1'b1, "R4");
  endtask

  // Builds the expected cycle stream for one access and the expected result.
  task automatic runCmd(input bit wr, input bit c45, input logic [4:0] phy,
                        input logic [20:0] addr, input logic [15:0] wd,
                        input bit taV, input logic [15:0] phyData, input bit poke);
    logic [15:0] expRd;
    bit          expErr;
    string       ftag;
    ftag = c45 ? "R8" : "R3";
    if (c45) begin
      pushHeader(2'b00, 2'b00, phy, addr[20:16], "R8");
      pushDrivenTail(addr[15:0], "R8");
    end
    pushHeader(c45 ? 2'b00 : 2'b01,
               c45 ? (wr ? 2'b01 : 2'b11) : (wr ? 2'b01 : 2'b10),
               phy, c45 ? addr[20:16] : addr[4:0], ftag);
    if (wr) begin
      pushDrivenTail(wd, "R4");
      expRd  = lastRd;
      expErr = 1'b0;
    end else begin
      pushBit(1'b0, 1'b0, RDH, taV, "R5");
      if (!taV || MASK[phy]) begin
        for (int i = 15; i >= 0; i--) pushBit(1'b0, 1'b0, RDH, phyData[i], taV ? "R7" : "R5");
        pushBit(1'b0, 1'b0, RDH, 1'b1, "R5");
        expRd  = phyData;
        expErr = 1'b0;
      end else begin
        for (int i = 0; i < 32; i++) pushBit(1'b0, 1'b0, RDH, 1'b1, "R6");
        expRd  = 16'hFFFF;
        expErr = 1'b1;
      end
    end

    cmdValid = 1'b1; cmdWrite = wr; cmdC45 = c45; cmdPhy = phy; cmdAddr = addr; cmdWdata = wd;
    @(negedge clk);
    cmdValid = 1'b0;
    begin
      int k;
      k = 0;
      while (qMdc.size() > 0) begin
        bit em, eo, eu, ei;
        string tg;
        em = qMdc.pop_front(); eo = qOe.pop_front(); eu = qOut.pop_front();
        ei = qIn.pop_front();  tg = qTag.pop_front();
        // R9: a second request while busy must change nothing
        if (poke && k >= 1 && k <= 10) begin
          cmdValid = 1'b1; cmdWrite = ~wr; cmdC45 = ~c45; cmdPhy = ~phy; cmdAddr = ~addr; cmdWdata = ~wd;
        end else begin
          cmdValid = 1'b0;
        end
        check({mdc, mdioOe, mdioOut & mdioOe, busy, done} == {em, eo, eu & eo, 1'b1, 1'b0},
              tg, {27'd0, mdc, mdioOe, mdioOut & mdioOe, busy, done},
              {27'd0, em, eo, eu & eo, 1'b1, 1'b0});
        mdioIn = ei;
        k++;
        @(negedge clk);
      end
    end
    cmdValid = 1'b0;
    mdioIn = 1'b1;
    check(done === 1'b1, "R10", {31'd0, done}, 32'd1);
    check(busy === 1'b0 && mdc === 1'b0 && mdioOe === 1'b0, "R9", {29'd0, busy, mdc, mdioOe}, 32'd0);
    check(rdData === expRd, wr ? "R10" : (expErr ? "R6" : "R5"), {16'd0, rdData}, {16'd0, expRd});
    check(taErr === expErr, wr ? "R10" : (expErr ? "R6" : "R5"), {31'd0, taErr}, {31'd0, expErr});
    lastRd = expRd;
    @(negedge clk);
    check(done === 1'b0, "R10", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    check({mdc, mdioOe, busy, done} == 4'b0000, "R1", {28'd0, mdc, mdioOe, busy, done}, 32'd0);
    repeat (2) @(negedge clk);
    check({mdc, mdioOe, busy, done} == 4'b0000, "R1", {28'd0, mdc, mdioOe, busy, done}, 32'd0);

    runCmd(1'b1, 1'b0, 5'd5,  21'h0001A, 16'hA5C3, 1'b0, 16'h0000, 1'b0); // R3 R4 short write
    runCmd(1'b0, 1'b0, 5'd3,  21'h00002, 16'h0000, 1'b0, 16'h1234, 1'b0); // R5 short read
    runCmd(1'b0, 1'b0, 5'd7,  21'h00011, 16'h0000, 1'b1, 16'h5555, 1'b0); // R6 bad turnaround
    runCmd(1'b0, 1'b0, 5'd9,  21'h0001F, 16'h0000, 1'b1, 16'h8001, 1'b0); // R7 excused
    runCmd(1'b1, 1'b1, 5'd1,  21'h1FBEEF, 16'h0F0F, 1'b0, 16'h0000, 1'b1); // R8 R9 ext write
    runCmd(1'b0, 1'b1, 5'd31, 21'h0A5A5A, 16'h0000, 1'b0, 16'hC0DE, 1'b0); // R8 ext read
    runCmd(1'b0, 1'b1, 5'd2,  21'h153C3C, 16'h0000, 1'b1, 16'h7777, 1'b1); // R6 R8 ext error
    runCmd(1'b1, 1'b0, 5'd4,  21'h00003, 16'h3C3C, 1'b0, 16'h0000, 1'b0); // R10 write after error

    repeat (3) @(negedge clk);
    check({mdc, mdioOe, busy, done} == 4'b0000, "R1", {28'd0, mdc, mdioOe, busy, done}, 32'd0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule